// File: doc/BRIEF.md
# Multiplexed DRAM Random-Port Cycle Controller

This block models the random-access side of a multiplexed-address DRAM. The active-low strobes (row strobe `ras_n`, column strobe `cas_n`, write strobe `we_n`, output strobe `oe_n`) are sampled on a fast system clock. Edges are found by comparing each sample with the one taken on the previous clock. The row address is taken from the shared address pins when the row strobe falls. The column address is taken on every column-strobe fall. The levels of the other strobes at the row-strobe fall choose what the whole row cycle does.

A row cycle can be a plain access (reads, early writes, late writes, several column cycles in page fashion) or a masked access. In a masked access a per-line write mask is loaded from the data pins. It can also be a refresh of the latched row when no column strobe arrives, or an internal refresh that takes its row from an on-block counter. A transfer cycle belongs to a neighbouring block; here it is only recognised and reported. At the end of every row cycle the block pulses `cyc_done` for one clock with the decoded kind. Refresh cycles also pulse `rf_valid` with the row they refreshed. The storage array is indexed by the low bits of the row and column addresses, and its size is set by parameters.

Top module: `dram_port_ctrl`

## Requirements
- R1: The row address is latched when `ras_n` falls and the column address when `cas_n` falls. Read data from that location appears on `dq_out`, with `dq_oe` high, one clock after the clock that samples the `cas_n` fall, provided `oe_n` is low.
- R2: Each row cycle ends with `cyc_done` high for exactly one clock, one clock after the `ras_n` rise is sampled. `cyc_type` then holds the kind: 1 = access, 2 = masked access, 3 = refresh with no column strobe, 4 = counter refresh, 5 = transfer. Reset value is 0.
- R3: If `ras_n` falls with `cas_n` high, `oe_n` high and `we_n` low, `dq_in` is loaded as a write mask. In each write, a mask bit of 1 lets its data line be written and a mask bit of 0 keeps the stored bit.
- R4: The mask stays in force for every column cycle of the same row cycle. It is replaced at the next `ras_n` fall.
- R5: If `we_n` is high when `ras_n` falls (with `cas_n` and `oe_n` high), all four data lines are written in that row cycle.
- R6: If `cas_n` is already low when `ras_n` falls, the cycle is a counter refresh. This takes priority over the levels of `oe_n` and `we_n`. The refreshed row is the counter value, which is 0 after reset and advances by one per such cycle. `rf_valid` pulses with `cyc_done`, and `rf_row` holds that row.
- R7: An access or masked row cycle with no `cas_n` fall is reported as kind 3. `rf_valid` pulses and `rf_row` holds the full 9-bit row address latched at the `ras_n` fall.
- R8: Write data is sampled at whichever comes later, the `cas_n` fall or the `we_n` fall. The value on `dq_in` at the earlier of the two is not written.
- R9: `dq_oe` drops one clock after whichever comes first, the `cas_n` rise or the `oe_n` rise.
- R10: If `we_n` is low when `cas_n` falls, `dq_oe` stays low for that whole column cycle, even with `oe_n` low.
- R11: If `cas_n` is held low from a read while `ras_n` rises and falls again, the new cycle is a counter refresh, and `dq_out` and `dq_oe` keep the read data. Several such refreshes can follow one another.
- R12: If `ras_n` falls with `cas_n` high and `oe_n` low, the cycle is a transfer. Column strobes and write strobes within it leave the array unchanged, and no refresh is reported.
- R13: After reset, `dq_oe`, `cyc_done` and `rf_valid` are low, and `dq_out` and `cyc_type` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every strobe |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 4 | Write data, or write mask at a masked row-strobe fall |
| dq_out | output | 4 | Read data |
| dq_oe | output | 1 | Read data driven |
| cyc_done | output | 1 | One-clock pulse at the end of a row cycle |
| cyc_type | output | 3 | Kind of the row cycle that just ended |
| rf_valid | output | 1 | One-clock pulse when the ended cycle was a refresh |
| rf_row | output | 9 | Row refreshed by that cycle |

## Verification
Most internal errors show up at the ports within one row cycle. A wrong decode shows up as a wrong `cyc_type` one clock after the row strobe rises. A stale or mis-latched mask shows up only when the affected word is read back in a later row cycle, as a wrong nibble on `dq_out`. A refresh counter that fails to advance shows up as a repeated `rf_row` on the next counter refresh. An output-enable flag that is wrong shows up as `dq_oe` high one clock after a strobe rise, during an early write, or as `dq_oe` low during a hidden refresh.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [2:0] {
        CK_NONE     = 3'd0,
        CK_ACCESS   = 3'd1,
        CK_MASKED   = 3'd2,
        CK_RAS_ONLY = 3'd3,
        CK_CBR      = 3'd4,
        CK_XFER     = 3'd5
    } cyc_kind_e;

endpackage

// File: rtl/dpc_strobe_edge.sv
module dpc_strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_d, prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign prev_d[i] = lvl_n[i];
        assign fall[i]   = prev_q[i] & ~lvl_n[i];
        assign rise[i]   = ~prev_q[i] & lvl_n[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/dpc_mode_decode.sv
module dpc_mode_decode
    import dpc_pkg::*;
(
    input  logic      cas_n,
    input  logic      we_n,
    input  logic      oe_n,
    output cyc_kind_e kind
);

    always_comb begin
        if (!cas_n)     kind = CK_CBR;
        else if (!oe_n) kind = CK_XFER;
        else if (!we_n) kind = CK_MASKED;
        else            kind = CK_ACCESS;
    end

endmodule

// File: rtl/dpc_cells.sv
module dpc_cells #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int DQ_W  = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic [DQ_W-1:0]  wr_data,
    input  logic [DQ_W-1:0]  wr_mask,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output logic [DQ_W-1:0]  rd_data
);

    localparam int AW    = ROW_W + COL_W;
    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] wa, ra;
    assign wa = {wr_row, wr_col};
    assign ra = {rd_row, rd_col};

    // one single-bit plane per data line, each with its own write enable
    for (genvar b = 0; b < DQ_W; b++) begin : g_lane
        logic plane [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b]) plane[wa] <= wr_data[b];
        end
        assign rd_data[b] = plane[ra];
    end

endmodule

// File: rtl/dram_port_ctrl.sv
module dram_port_ctrl
    import dpc_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int DQ_W      = 4,
    parameter int ARR_ROW_W = 4,
    parameter int ARR_COL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              cyc_done,
    output logic [2:0]        cyc_type,
    output logic              rf_valid,
    output logic [ADDR_W-1:0] rf_row
);

    localparam int RASB = 1;
    localparam int CASB = 0;

    typedef struct packed {
        logic [ADDR_W-1:0]    row;
        logic [ARR_COL_W-1:0] col;
        logic [ADDR_W-1:0]    rfcnt;
        logic [ADDR_W-1:0]    rf_row;
        logic [DQ_W-1:0]      mask;
        logic [DQ_W-1:0]      dout;
        cyc_kind_e            kind;
        cyc_kind_e            rpt;
        logic                 we_prev;
        logic                 in_ras;
        logic                 acc_seen;
        logic                 cas_act;
        logic                 armed;
        logic                 drv;
        logic                 done;
        logic                 rfv;
    } st_t;

    st_t d, q;

    logic [1:0] st_fall, st_rise;
    logic       ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    cyc_kind_e  dec_kind, fin_kind;
    logic       access_ok, wr_en;
    logic [ARR_COL_W-1:0] wr_col;
    logic [DQ_W-1:0]      rd_data;

    dpc_strobe_edge #(.N(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n ({ras_n, cas_n}),
        .fall  (st_fall),
        .rise  (st_rise)
    );

    assign ras_fall = st_fall[RASB];
    assign ras_rise = st_rise[RASB];
    assign cas_fall = st_fall[CASB];
    assign cas_rise = st_rise[CASB];
    assign we_fall  = q.we_prev & ~we_n;

    dpc_mode_decode u_dec (
        .cas_n (cas_n),
        .we_n  (we_n),
        .oe_n  (oe_n),
        .kind  (dec_kind)
    );

    dpc_cells #(
        .ROW_W (ARR_ROW_W),
        .COL_W (ARR_COL_W),
        .DQ_W  (DQ_W)
    ) u_cells (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_row  (q.row[ARR_ROW_W-1:0]),
        .wr_col  (wr_col),
        .wr_data (dq_in),
        .wr_mask (q.mask),
        .rd_row  (q.row[ARR_ROW_W-1:0]),
        .rd_col  (addr[ARR_COL_W-1:0]),
        .rd_data (rd_data)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.rfv     = 1'b0;
        d.we_prev = we_n;
        wr_en     = 1'b0;
        wr_col    = q.col;
        fin_kind  = q.kind;
        access_ok = q.in_ras && !ras_n &&
                    (q.kind == CK_ACCESS || q.kind == CK_MASKED);

        // row strobe: open decodes the cycle, close reports it
        if (ras_fall) begin
            d.in_ras   = 1'b1;
            d.acc_seen = 1'b0;
            d.kind     = dec_kind;
            d.row      = addr;
            d.mask     = (dec_kind == CK_MASKED) ? dq_in : '1;
            if (dec_kind == CK_CBR) begin
                d.row   = q.rfcnt;
                d.rfcnt = q.rfcnt + 1'b1;
            end
        end else if (ras_rise && q.in_ras) begin
            if ((q.kind == CK_ACCESS || q.kind == CK_MASKED) && !q.acc_seen)
                fin_kind = CK_RAS_ONLY;
            d.in_ras = 1'b0;
            d.done   = 1'b1;
            d.rpt    = fin_kind;
            d.rfv    = (fin_kind == CK_RAS_ONLY) || (fin_kind == CK_CBR);
            d.rf_row = q.row;
        end

        // column strobe: early write, read launch, or late write on write strobe
        if (access_ok && cas_fall) begin
            d.col      = addr[ARR_COL_W-1:0];
            d.acc_seen = 1'b1;
            d.cas_act  = 1'b1;
            if (!we_n) begin
                wr_en   = 1'b1;
                wr_col  = addr[ARR_COL_W-1:0];
                d.armed = 1'b0;
            end else begin
                d.armed = 1'b1;
                d.dout  = rd_data;
            end
        end else if (access_ok && we_fall && q.cas_act && !cas_n) begin
            wr_en = 1'b1;
        end

        if (cas_rise) begin
            d.armed   = 1'b0;
            d.cas_act = 1'b0;
        end

        d.drv = d.armed && !oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.mask    <= '1;
            q.we_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign dq_out   = q.dout;
    assign dq_oe    = q.drv;
    assign cyc_done = q.done;
    assign cyc_type = q.rpt;
    assign rf_valid = q.rfv;
    assign rf_row   = q.rf_row;

    AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        q.drv |-> $past(!cas_n && !oe_n)); // R9
    AST_EARLY_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (access_ok && cas_fall && !we_n) |=> !q.drv); // R10
    AST_CBR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && !cas_n) |=> (q.rfcnt == $past(q.rfcnt) + 1'b1)); // R6
    AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(ras_rise)); // R2
    AST_NO_WRITE_NONACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.in_ras && (q.kind == CK_CBR || q.kind == CK_XFER)) |-> !wr_en); // R12
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.in_ras && !ras_fall) |=> $stable(q.mask)); // R4

endmodule

// File: tb/dram_port_ctrl_bench.sv
module dram_port_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam logic [8:0] V_ROW [NV] = '{9'h003, 9'h10C, 9'h0F7, 9'h021, 9'h1F0, 9'h055};
    localparam logic [8:0] V_COL [NV] = '{9'h004, 9'h0A9, 9'h13E, 9'h000, 9'h1FF, 9'h082};
    localparam logic [3:0] V_DAT [NV] = '{4'h5, 4'hA, 4'hF, 4'h0, 4'h3, 4'hC};

    logic       clk = 1'b0;
    logic       rst_n, ras_n, cas_n, we_n, oe_n;
    logic [8:0] addr;
    logic [3:0] dq_in, dq_out;
    logic       dq_oe, cyc_done, rf_valid;
    logic [2:0] cyc_type;
    logic [8:0] rf_row;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic       done_s, rfv_s;
    logic [2:0] type_s;
    logic [8:0] rfrow_s;
    logic [8:0] exp_cnt = 9'd0;
    logic [3:0] rd_v;
    logic       oe_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_port_ctrl u_dram_port_ctrl (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .cyc_done(cyc_done), .cyc_type(cyc_type), .rf_valid(rf_valid), .rf_row(rf_row)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ras_open(input logic [8:0] row, input logic we_lvl,
                            input logic [3:0] msk, input logic oe_lvl);
        addr = row; we_n = we_lvl; oe_n = oe_lvl; dq_in = msk; ras_n = 1'b0;
        step();
        we_n = 1'b1; oe_n = 1'b1; dq_in = 4'h0;
    endtask

    task automatic ras_close();
        ras_n = 1'b1;
        step();
        done_s = cyc_done; type_s = cyc_type; rfv_s = rf_valid; rfrow_s = rf_row;
        step();
    endtask

    task automatic cas_wr(input logic [8:0] col, input logic [3:0] dat,
                          input logic oe_lvl, output logic oe_seen);
        addr = col; dq_in = dat; we_n = 1'b0; oe_n = oe_lvl; cas_n = 1'b0;
        step();
        oe_seen = dq_oe;
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        step();
    endtask

    task automatic cas_rd(input logic [8:0] col, output logic [3:0] dat, output logic oe_seen);
        addr = col; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0;
        step();
        dat = dq_out; oe_seen = dq_oe;
        cas_n = 1'b1; oe_n = 1'b1;
        step();
    endtask

    task automatic read_loc(input logic [8:0] row, input logic [8:0] col,
                            input logic [3:0] exp, input string req);
        ras_open(row, 1'b1, 4'h0, 1'b1);
        cas_rd(col, rd_v, oe_v);
        chk(req, rd_v, exp);
        ras_close();
    endtask

    task automatic write_loc(input logic [8:0] row, input logic [8:0] col, input logic [3:0] dat);
        ras_open(row, 1'b1, 4'h0, 1'b1);
        cas_wr(col, dat, 1'b1, oe_v);
        ras_close();
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL R13 watchdog act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; dq_in = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R13: reset state
        chk("R13 dq_oe", dq_oe, 0);
        chk("R13 cyc_done", cyc_done, 0);
        chk("R13 rf_valid", rf_valid, 0);
        chk("R13 dq_out", dq_out, 0);
        chk("R13 cyc_type", cyc_type, 0);

        // R1 R2 R5: table of plain writes, then reads
        for (int i = 0; i < NV; i++) begin
            write_loc(V_ROW[i], V_COL[i], V_DAT[i]);
            chk("R2 done access", done_s, 1);
            chk("R2 type access", type_s, 1);
            chk("R2 no refresh on access", rfv_s, 0);
        end
        for (int i = 0; i < NV; i++) begin
            ras_open(V_ROW[i], 1'b1, 4'h0, 1'b1);
            cas_rd(V_COL[i], rd_v, oe_v);
            chk("R1 read data", rd_v, V_DAT[i]);
            chk("R1 read oe", oe_v, 1);
            ras_close();
        end

        // R3 R4 R10: masked page writes
        write_loc(9'h00B, 9'h001, 4'hA);
        write_loc(9'h00B, 9'h002, 4'h3);
        write_loc(9'h00B, 9'h003, 4'h6);
        ras_open(9'h00B, 1'b0, 4'b0110, 1'b1);
        cas_wr(9'h001, 4'h5, 1'b0, oe_v);
        chk("R10 early write keeps oe low", oe_v, 0);
        cas_wr(9'h002, 4'hF, 1'b1, oe_v);
        ras_close();
        chk("R2 type masked", type_s, 2);
        read_loc(9'h00B, 9'h001, 4'hC, "R3 masked write");
        read_loc(9'h00B, 9'h002, 4'h7, "R4 mask held over page");

        // R5: unmasked row cycle after a masked one
        write_loc(9'h00B, 9'h003, 4'h9);
        read_loc(9'h00B, 9'h003, 4'h9, "R5 full write");

        // R3: all-zero mask inhibits every line
        ras_open(9'h00B, 1'b0, 4'b0000, 1'b1);
        cas_wr(9'h003, 4'hF, 1'b1, oe_v);
        ras_close();
        read_loc(9'h00B, 9'h003, 4'h9, "R3 zero mask inhibits");

        // R8: late write takes data at write-strobe fall
        ras_open(9'h00D, 1'b1, 4'h0, 1'b1);
        addr = 9'h004; dq_in = 4'h0; we_n = 1'b1; oe_n = 1'b1; cas_n = 1'b0;
        step();
        dq_in = 4'hD; we_n = 1'b0;
        step();
        dq_in = 4'h0;
        step();
        we_n = 1'b1; cas_n = 1'b1;
        step();
        ras_close();
        read_loc(9'h00D, 9'h004, 4'hD, "R8 late write data");

        // R9: output strobe rises first
        ras_open(9'h00B, 1'b1, 4'h0, 1'b1);
        addr = 9'h001; oe_n = 1'b0; cas_n = 1'b0;
        step();
        chk("R9 drive before oe rise", dq_oe, 1);
        oe_n = 1'b1;
        step();
        chk("R9 oe rise releases", dq_oe, 0);
        cas_n = 1'b1;
        step();
        ras_close();

        // R9: column strobe rises first
        ras_open(9'h00B, 1'b1, 4'h0, 1'b1);
        addr = 9'h001; oe_n = 1'b0; cas_n = 1'b0;
        step();
        chk("R9 drive before cas rise", dq_oe, 1);
        cas_n = 1'b1;
        step();
        chk("R9 cas rise releases", dq_oe, 0);
        oe_n = 1'b1;
        ras_close();

        // R11 R6: hidden refresh, then back-to-back counter refreshes
        ras_open(9'h00B, 1'b1, 4'h0, 1'b1);
        addr = 9'h001; oe_n = 1'b0; cas_n = 1'b0;
        step();
        ras_n = 1'b1;
        step();
        chk("R2 type before hidden", cyc_type, 1);
        chk("R11 oe across ras rise", dq_oe, 1);
        ras_n = 1'b0;
        step();
        chk("R11 data during refresh", dq_out, 4'hC);
        ras_n = 1'b1;
        step();
        chk("R6 type cbr", cyc_type, 4);
        chk("R6 rf_valid", rf_valid, 1);
        chk("R6 first counter row", rf_row, exp_cnt);
        chk("R11 oe after refresh", dq_oe, 1);
        exp_cnt = exp_cnt + 1'b1;
        for (int k = 0; k < 3; k++) begin
            ras_n = 1'b0;
            step();
            ras_n = 1'b1;
            step();
            chk("R6 counter advances", rf_row, exp_cnt);
            exp_cnt = exp_cnt + 1'b1;
        end
        chk("R11 data kept", dq_out, 4'hC);
        cas_n = 1'b1; oe_n = 1'b1;
        step();
        chk("R9 release after hidden", dq_oe, 0);

        // R7: row-only refresh
        ras_open(9'h1A5, 1'b1, 4'h0, 1'b1);
        step();
        ras_close();
        chk("R7 type", type_s, 3);
        chk("R7 rf_valid", rfv_s, 1);
        chk("R7 rf_row", rfrow_s, 9'h1A5);

        // R12: transfer cycle does not touch the array
        ras_open(9'h00B, 1'b1, 4'h0, 1'b0);
        cas_wr(9'h003, 4'hE, 1'b1, oe_v);
        ras_close();
        chk("R12 type xfer", type_s, 5);
        chk("R12 no refresh", rfv_s, 0);
        read_loc(9'h00B, 9'h003, 4'h9, "R12 array unchanged");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule